// File: doc/BRIEF.md
# Modem Line Status and Control Register Pair

This block holds the two modem-facing registers of a 16550-style serial port. A control register, written over a byte-wide register port, drives four outgoing handshake lines: data-terminal-ready, request-to-send and two general outputs. A status register reports the present level of four incoming lines (clear-to-send, data-set-ready, ring indicator and carrier detect) in its upper nibble. Its lower nibble holds sticky change flags that the interrupt logic of the port sees through a single pending output.

The incoming lines are asynchronous. Each passes a first capture flop. The stored level register acts as the second synchroniser stage, and the change flags are formed by comparing the stored level with the captured value. The ring-indicator flag is raised only when the ring line falls; a rising ring line leaves it alone. Reading the status register clears the four change flags. In loopback the control bits are fed back into the status read path, the outgoing lines are held low and the incoming lines are not sampled.

A small mode state machine controls the sampling. After reset it passes through `ST_SETTLE_A`, where the capture flop fills, and then `ST_SETTLE_B`, where the level register loads without raising flags. It then enters `ST_NORMAL` if the loop bit is clear or `ST_LOOP` if it is set. `ST_NORMAL` moves to `ST_LOOP` on a control write with the loop bit set. `ST_LOOP` returns to `ST_NORMAL` on a control write with the loop bit clear. Levels are sampled only in `ST_NORMAL`.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0x08 (only the general output 2 bit set), drv_out2 is 1, the other outgoing lines are 0, delta_pend is 0, and once the two settle cycles have passed the status register shows the line levels with all four change flags at 0.
- R2: Outside loopback, the status upper nibble reports carrier detect in bit 7, ring in bit 6, data-set-ready in bit 5 and clear-to-send in bit 4, and a line change is visible there after the second rising clock edge following it.
- R3: A change in either direction on clear-to-send, data-set-ready or carrier detect sets status bit 0, 1 or 3 respectively, in the same cycle as the level update, and the flag stays set until a status read.
- R4: Status bit 2 is set when the ring line goes from 1 to 0 and is never set by a 0 to 1 ring transition.
- R5: A status read (reg_rd=1, reg_sel=1) returns the current value and clears the four change flags at that clock edge. A change whose flag would be raised at the same edge is kept.
- R6: delta_pend is 1 exactly when at least one of the four change flags is set.
- R7: A control write (reg_wr=1, reg_sel=0) stores only data bits 4:0: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 general output 1, bit 3 general output 2, bit 4 loop. Bits 7:5 read back as 0. Outside loopback each outgoing line follows its bit.
- R8: While the loop bit is set, a status read returns general output 2 in bit 7, general output 1 in bit 6, data-terminal-ready in bit 5 and request-to-send in bit 4, with bits 3:0 reading 0. Such a read clears no change flag.
- R9: While the loop bit is set, all four outgoing lines are 0, and the stored levels and flags ignore the incoming lines. After loopback is left, any difference between the frozen levels and the lines raises change flags as in R3 and R4.
- R10: A write addressed to the status register (reg_wr=1, reg_sel=1) changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear side effect on status) |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| line_cts | input | 1 | Incoming clear-to-send level |
| line_dsr | input | 1 | Incoming data-set-ready level |
| line_ri | input | 1 | Incoming ring indicator level |
| line_dcd | input | 1 | Incoming carrier detect level |
| drv_dtr | output | 1 | Outgoing data-terminal-ready |
| drv_rts | output | 1 | Outgoing request-to-send |
| drv_out1 | output | 1 | General output 1 |
| drv_out2 | output | 1 | General output 2 |
| delta_pend | output | 1 | Some change flag is set |

## Verification
The central collision occurs when a status read clears the change flags at the same clock edge that a new line change sets one. The bench times a data-set-ready toggle so that its level update falls on the read edge. It then expects the old ring flag to be gone and the new flag to remain. A second collision is a line change that arrives during loopback and overlaps the control write that leaves loopback. The bench expects the flag one edge after that write, because the state machine is still in `ST_LOOP` at the write edge. A behavioural model running in the bench is compared with every output on every clock. It also covers cases the directed checks do not name.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_LINES = 4;
    localparam int CTRL_W    = 5;

    // Line index inside the level and flag nibbles
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    localparam logic SEL_CTRL   = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

    localparam logic [DATA_W-1:0] CTRL_MASK  = DATA_W'((1 << CTRL_W) - 1);
    localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(8'h08);

    typedef enum logic [1:0] {
        ST_SETTLE_A = 2'd0,
        ST_SETTLE_B = 2'd1,
        ST_NORMAL   = 2'd2,
        ST_LOOP     = 2'd3
    } mode_state_e;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctrl_bits_t;

endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] meta_o
);

    // First synchroniser stage; the level register downstream is the second
    logic [WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= async_i;
        end
    end

    assign meta_o = stage_q;

endmodule

// File: rtl/modem_status_track.sv
module modem_status_track #(
    parameter int WIDTH  = 4,
    parameter int RI_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             load_quiet,
    input  logic             clr_delta,
    input  logic [WIDTH-1:0] meta_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] delta_o
);

    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] delta_q;
    logic [WIDTH-1:0] new_delta;

    for (genvar i = 0; i < WIDTH; i++) begin : g_edge
        if (i == RI_IDX) begin : g_fall_only
            assign new_delta[i] = sample_en & level_q[i] & ~meta_i[i];
        end else begin : g_any_edge
            assign new_delta[i] = sample_en & (level_q[i] ^ meta_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            delta_q <= '0;
        end else begin
            if (sample_en || load_quiet) begin
                level_q <= meta_i;
            end
            delta_q <= (clr_delta ? '0 : delta_q) | new_delta;
        end
    end

    assign level_o = level_q;
    assign delta_o = delta_q;

    // R4: a rising ring line never raises its flag
    a_r4_no_flag_on_ring_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !level_q[RI_IDX] && meta_i[RI_IDX] && !delta_q[RI_IDX])
        |=> !delta_q[RI_IDX]);

    // R3: flags are sticky when no read clears them
    a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_delta |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R5: after a clearing read only lines that moved at that edge may be flagged
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_delta |=> ((delta_q & ~($past(level_q) ^ level_q)) == '0));

    // R9: levels hold while sampling is off
    a_r9_levels_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !load_quiet) |=> $stable(level_q));

endmodule

// File: rtl/modem_ctrl_fsm.sv
module modem_ctrl_fsm
    import uart_modem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [DATA_W-1:0]    ctrl_wdata,
    output logic [DATA_W-1:0]    ctrl_byte_o,
    output logic                 sample_en_o,
    output logic                 load_quiet_o
);

    mode_state_e       state_q;
    mode_state_e       state_d;
    logic [DATA_W-1:0] ctrl_q;
    logic              loop_next;

    assign loop_next = ctrl_wr ? ctrl_wdata[CTRL_W-1] : ctrl_q[CTRL_W-1];

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_wdata & CTRL_MASK;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE_A;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE_A: state_d = ST_SETTLE_B;
            ST_SETTLE_B: state_d = loop_next ? ST_LOOP : ST_NORMAL;
            ST_NORMAL:   state_d = loop_next ? ST_LOOP : ST_NORMAL;
            ST_LOOP:     state_d = loop_next ? ST_LOOP : ST_NORMAL;
            default:     state_d = ST_SETTLE_A;
        endcase
    end

    // Outputs
    always_comb begin
        sample_en_o  = 1'b0;
        load_quiet_o = 1'b0;
        unique case (state_q)
            ST_SETTLE_A: ;
            ST_SETTLE_B: load_quiet_o = 1'b1;
            ST_NORMAL:   sample_en_o  = 1'b1;
            ST_LOOP:     ;
            default:     ;
        endcase
    end

    assign ctrl_byte_o = ctrl_q;

    // R9: after settling, the loop state always agrees with the stored loop bit
    a_r9_state_matches_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL || state_q == ST_LOOP)
        |-> ((state_q == ST_LOOP) == ctrl_q[CTRL_W-1]));

    // R7: bits above the control field never become set
    a_r7_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ((ctrl_q & ~CTRL_MASK) == '0));

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              line_cts,
    input  logic              line_dsr,
    input  logic              line_ri,
    input  logic              line_dcd,
    output logic              drv_dtr,
    output logic              drv_rts,
    output logic              drv_out1,
    output logic              drv_out2,
    output logic              delta_pend
);

    logic [NUM_LINES-1:0] lines_async;
    logic [NUM_LINES-1:0] lines_meta;
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] delta;
    logic [DATA_W-1:0]    ctrl_byte;
    ctrl_bits_t           ctrl;
    logic                 sample_en;
    logic                 load_quiet;
    logic                 clr_delta;
    logic                 ctrl_wr;
    logic [DATA_W-1:0]    status_live;
    logic [DATA_W-1:0]    status_loop;

    always_comb begin
        lines_async          = '0;
        lines_async[IDX_CTS] = line_cts;
        lines_async[IDX_DSR] = line_dsr;
        lines_async[IDX_RI]  = line_ri;
        lines_async[IDX_DCD] = line_dcd;
    end

    modem_line_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lines_async),
        .meta_o  (lines_meta)
    );

    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

    modem_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (reg_wdata),
        .ctrl_byte_o  (ctrl_byte),
        .sample_en_o  (sample_en),
        .load_quiet_o (load_quiet)
    );

    assign ctrl      = ctrl_bits_t'(ctrl_byte[CTRL_W-1:0]);
    assign clr_delta = reg_rd && (reg_sel == SEL_STATUS) && !ctrl.loop;

    modem_status_track #(.WIDTH(NUM_LINES), .RI_IDX(IDX_RI)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .load_quiet (load_quiet),
        .clr_delta  (clr_delta),
        .meta_i     (lines_meta),
        .level_o    (level),
        .delta_o    (delta)
    );

    assign status_live = {level, delta};
    assign status_loop = {ctrl.out2, ctrl.out1, ctrl.dtr, ctrl.rts, {NUM_LINES{1'b0}}};

    always_comb begin
        if (reg_sel == SEL_STATUS) begin
            reg_rdata = ctrl.loop ? status_loop : status_live;
        end else begin
            reg_rdata = ctrl_byte;
        end
    end

    assign drv_dtr    = ctrl.dtr  & ~ctrl.loop;
    assign drv_rts    = ctrl.rts  & ~ctrl.loop;
    assign drv_out1   = ctrl.out1 & ~ctrl.loop;
    assign drv_out2   = ctrl.out2 & ~ctrl.loop;
    assign delta_pend = |delta;

    // R10: a write addressed to status leaves the control register alone
    a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_STATUS) |=> $stable(ctrl_byte));

    // R8: a loopback read leaves the change flags untouched
    a_r8_loop_read_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_STATUS && ctrl.loop && !sample_en)
        |=> $stable(delta));

endmodule

// File: tb/uart_modem_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_modem_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       line_cts = 1'b1;
    logic       line_dsr = 1'b1;
    logic       line_ri  = 1'b0;
    logic       line_dcd = 1'b1;
    logic       drv_dtr, drv_rts, drv_out1, drv_out2, delta_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit model_live = 1'b0;

    // Behavioural reference state
    int m_meta, m_lvl, m_dlt, m_ctl, m_settle;

    always #4 clk = ~clk;

    uart_modem_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri),
        .line_dcd(line_dcd), .drv_dtr(drv_dtr), .drv_rts(drv_rts),
        .drv_out1(drv_out1), .drv_out2(drv_out2), .delta_pend(delta_pend)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_meta = 0; m_lvl = 0; m_dlt = 0; m_ctl = 8; m_settle = 0;
            model_live = 1'b1;
        end else begin
            int lines, nd, nl;
            bit loopm, clr;
            lines = (line_dcd << 3) | (line_ri << 2) | (line_dsr << 1) | line_cts;
            loopm = m_ctl[4];
            clr   = reg_rd && reg_sel && !loopm;
            nd = 0;
            nl = m_lvl;
            if (m_settle == 0) begin
                m_settle = 1;
            end else if (m_settle == 1) begin
                nl = m_meta;
                m_settle = 2;
            end else if (!loopm) begin
                for (int i = 0; i < 4; i++) begin
                    if (m_lvl[i] != m_meta[i]) begin
                        if (i != 2 || m_lvl[i]) nd = nd | (1 << i);
                    end
                end
                nl = m_meta;
            end
            m_dlt  = (clr ? 0 : m_dlt) | nd;
            m_lvl  = nl;
            m_meta = lines;
            if (reg_wr && !reg_sel) m_ctl = reg_wdata & 8'h1F;
        end
    end

    always @(negedge clk) begin
        if (model_live && !done) begin
            int exp_rd, exp_out;
            bit loopm;
            loopm = m_ctl[4];
            if (!reg_sel) begin
                check("R7 ctrl read", reg_rdata, m_ctl);
            end else if (loopm) begin
                exp_rd = (m_ctl[3] << 7) | (m_ctl[2] << 6) | (m_ctl[0] << 5) | (m_ctl[1] << 4);
                check("R8 loop status read", reg_rdata, exp_rd);
            end else begin
                check("R2 status read", reg_rdata, ((m_lvl << 4) | m_dlt) & 8'hFF);
            end
            exp_out = loopm ? 0 : (m_ctl & 4'hF);
            check("R9 outgoing lines", {drv_out2, drv_out1, drv_rts, drv_dtr}, exp_out);
            check("R6 delta_pend", delta_pend, (m_dlt != 0) ? 1 : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic view(bit sel, string tag, int exp);
        reg_sel = sel;
        @(negedge clk);
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();
        // R1 reset state after settling: dcd, dsr, cts high, no flags
        view(1'b0, "R1 ctrl reset", 8'h08);
        check("R1 out2 at reset", {drv_out2, drv_out1, drv_rts, drv_dtr}, 4'b1000);
        view(1'b1, "R1 status after settle", 8'hB0);
        check("R1 pend at reset", delta_pend, 0);

        // R2 and R3: clear-to-send falls
        tick(); line_cts = 1'b0;
        tick();
        view(1'b1, "R2 not yet visible", 8'hB0);
        tick();
        view(1'b1, "R3 cts flag", 8'hA1);
        check("R6 pend set", delta_pend, 1);

        // R5: read clears
        tick(); reg_rd = 1'b1; reg_sel = 1'b1;
        @(negedge clk); check("R5 read value", reg_rdata, 8'hA1);
        tick(); reg_rd = 1'b0;
        view(1'b1, "R5 flags cleared", 8'hA0);
        check("R6 pend cleared", delta_pend, 0);

        // R4: ring rises then falls
        tick(); line_ri = 1'b1;
        tick(); tick();
        view(1'b1, "R4 no flag on rise", 8'hE0);
        tick(); line_ri = 1'b0;
        tick(); tick();
        view(1'b1, "R4 flag on fall", 8'hA4);

        // R5 collision: read edge coincides with dsr level update
        tick(); line_dsr = 1'b0;
        tick(); reg_rd = 1'b1; reg_sel = 1'b1;
        @(negedge clk); check("R5 collision pre-read", reg_rdata, 8'hA4);
        tick(); reg_rd = 1'b0;
        view(1'b1, "R5 new flag survives clear", 8'h82);

        // R7: control write masks upper bits, enters loop
        tick(); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hFF;
        tick(); reg_wr = 1'b0;
        view(1'b0, "R7 ctrl masked", 8'h1F);
        check("R9 lines idle in loop", {drv_out2, drv_out1, drv_rts, drv_dtr}, 0);
        view(1'b1, "R8 loop map all", 8'hF0);

        tick(); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h15;
        tick(); reg_wr = 1'b0;
        view(1'b1, "R8 loop map out1 dtr", 8'h60);

        // R8 loop read does not clear; R9 line changes ignored
        tick(); reg_rd = 1'b1; reg_sel = 1'b1; line_cts = 1'b1;
        tick(); reg_rd = 1'b0;
        tick(); tick();
        check("R8 pend kept in loop", delta_pend, 1);

        // R9 leave loop: frozen levels compared against lines
        tick(); reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h03;
        tick(); reg_wr = 1'b0;
        check("R7 outputs follow ctrl", {drv_out2, drv_out1, drv_rts, drv_dtr}, 4'b0011);
        view(1'b1, "R9 frozen just after exit", 8'h82);
        tick();
        view(1'b1, "R9 change seen after exit", 8'h93);

        // R10: status write ignored
        tick(); reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'hFF;
        tick(); reg_wr = 1'b0;
        view(1'b1, "R10 status unchanged", 8'h93);
        view(1'b0, "R10 ctrl unchanged", 8'h03);

        tick(); tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule